// File: doc/BRIEF.md
# Pipelined Symmetric Eight-Tap FIR Filter

This block is a streaming eight-tap FIR filter for signed fixed-point samples. It exploits coefficient symmetry: the two taps that share a weight are added first, so four multipliers do the work of eight. One sample and four runtime weights are accepted on every clock. A registered two-level adder tree sums the four products at full precision.

The datapath is cut into short register stages so that each multiply sits alone between registers and maps onto a hardware multiplier block at a 200 MHz class clock. There is an input register, a pre-add stage, a product stage, a partial-sum stage and an output register. A side output gives the oldest sample in the delay line. It is delayed by the same number of stages as the filtered result, so the two outputs can be used together in the same cycle.

Top module: `sfir_pipe`

## Requirements
- R1: A synchronous active-low reset clears the delay line and every pipeline register. On the first clock edge with `rst_n` low, both outputs become zero. They stay zero until nonzero data has passed through the pipeline.
- R2: Let edge k be the edge that captures sample x[k]. After edge k+4, `smp_tail` equals x[k-8]. This is the sample captured 12 edges earlier. Samples from before the last reset count as zero.
- R3: Let h0..h3 be the values on `coef0`..`coef3` at edge k. After edge k+4, `y_out` equals h0*(x[k-1]+x[k-8]) + h1*(x[k-2]+x[k-7]) + h2*(x[k-3]+x[k-6]) + h3*(x[k-4]+x[k-5]).
- R4: The coefficients are captured at the same edge as the sample. A change of the coefficient inputs at edge k first shows in `y_out` after edge k+4, and not before.
- R5: Precision is full, with no rounding and no wrap. Pre-add sums are DATA_W+1 bits. `y_out` is DATA_W+COEF_W+3 bits. The extreme input values give exact results.
- R6: Take a single unit sample at edge k, with zero data around it and constant weights. After edges k+5 through k+12, `y_out` shows h0, h1, h2, h3, h3, h2, h1, h0.
- R7: If all four coefficients are zero at edge k, `y_out` is zero after edge k+4, whatever the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | DATA_W | Signed input sample, one per clock |
| coef0 | input | COEF_W | Signed weight for the outermost tap pair (newest and oldest) |
| coef1 | input | COEF_W | Signed weight for the second tap pair |
| coef2 | input | COEF_W | Signed weight for the third tap pair |
| coef3 | input | COEF_W | Signed weight for the innermost tap pair |
| y_out | output | DATA_W+COEF_W+3 | Signed filtered result, full precision |
| smp_tail | output | DATA_W | Oldest delay-line sample, aligned with `y_out` |

## Verification
The hardest situation to reach is the worst-case growth through the pre-adders and the adder tree. There, every tap holds the most negative sample and every weight is the most negative coefficient, so each product and both partial sums sit at their largest magnitude at once. Random data almost never lines up like this. Directed runs therefore fill the whole delay line with the extreme value and hold the weights extreme long enough for all four products to be maximal in the same cycle. The same is done with the most positive sample. Coefficient changes of a single cycle, placed in the middle of constant data, show whether the weights and the samples stay aligned through the stages.

// File: rtl/sfir_pkg.sv
// Shared constants for the symmetric FIR pipeline.
// Assumes an even tap count folded into pairs by pre-adders.
package sfir_pkg;
    localparam int NUM_TAPS    = 8;
    localparam int NUM_PAIRS   = NUM_TAPS / 2;
    // register stages after the tap line: pre-add, product, half sum, output
    localparam int POST_STAGES = 4;
endpackage

// File: rtl/sfir_tapline.sv
// Input register stage and tap delay line.
// Captures sample and weights together; shifts the sample toward the last tap.
// Assumes one new sample on every clock edge.
module sfir_tapline #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = sfir_pkg::NUM_TAPS,
    localparam int PAIRS = TAPS / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic signed [COEF_W-1:0] coef_in [PAIRS],
    output logic signed [DATA_W-1:0] tap_q   [TAPS],
    output logic signed [COEF_W-1:0] coef_q  [PAIRS]
);
    logic signed [DATA_W-1:0] smp_q;
    logic [4:0]               age_q;

    // input register: sample and weights captured on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_in;
    end

    for (genvar c = 0; c < PAIRS; c++) begin : g_coef
        // weight input register for pair c
        always_ff @(posedge clk) begin
            if (!rst_n) coef_q[c] <= '0;
            else        coef_q[c] <= coef_in[c];
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        if (t == 0) begin : g_head
            // first tap takes the registered sample
            always_ff @(posedge clk) begin
                if (!rst_n) tap_q[t] <= '0;
                else        tap_q[t] <= smp_q;
            end
        end else begin : g_body
            // later taps take their neighbour toward the head
            always_ff @(posedge clk) begin
                if (!rst_n) tap_q[t] <= '0;
                else        tap_q[t] <= tap_q[t-1];
            end
        end
    end

    // edges since reset, saturating, for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 5'h1f) age_q <= age_q + 5'd1;
    end

    // R2
    tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 5'd8) |-> (tap_q[TAPS-1] == $past(smp_q, 8)));
endmodule

// File: rtl/sfir_preadd.sv
// Symmetric fold: adds each tap to its mirror tap, one bit wider.
// Forwards the weights by one stage to keep them aligned with the sums.
module sfir_preadd #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = sfir_pkg::NUM_TAPS,
    localparam int PAIRS = TAPS / 2,
    localparam int PRE_W = DATA_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] tap_in  [TAPS],
    input  logic signed [COEF_W-1:0] coef_in [PAIRS],
    output logic signed [PRE_W-1:0]  sum_q   [PAIRS],
    output logic signed [COEF_W-1:0] coef_q  [PAIRS]
);
    logic live_q;

    // marks that the previous edge was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        // mirror-pair sum with one bit of growth
        always_ff @(posedge clk) begin
            if (!rst_n) sum_q[g] <= '0;
            else        sum_q[g] <= PRE_W'(tap_in[g]) + PRE_W'(tap_in[TAPS-1-g]);
        end

        // weight delay matching the pre-add stage
        always_ff @(posedge clk) begin
            if (!rst_n) coef_q[g] <= '0;
            else        coef_q[g] <= coef_in[g];
        end

        // R5
        pre_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(tap_in[g][DATA_W-1]) && $past(tap_in[TAPS-1-g][DATA_W-1]))
            |-> sum_q[g][PRE_W-1]);
    end
endmodule

// File: rtl/sfir_mult.sv
// Registered multiply stage, one product per folded pair.
// Each multiply has registers on both sides to fit a hardware multiplier.
module sfir_mult #(
    parameter int PRE_W  = 17,
    parameter int COEF_W = 16,
    parameter int PAIRS  = sfir_pkg::NUM_PAIRS,
    localparam int PROD_W = PRE_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PRE_W-1:0]  sum_in  [PAIRS],
    input  logic signed [COEF_W-1:0] coef_in [PAIRS],
    output logic signed [PROD_W-1:0] prod_q  [PAIRS]
);
    logic live_q;

    // marks that the previous edge was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    for (genvar g = 0; g < PAIRS; g++) begin : g_mul
        // full-width signed product register
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q[g] <= '0;
            else        prod_q[g] <= PROD_W'(sum_in[g]) * PROD_W'(coef_in[g]);
        end

        // R7
        zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && ($past(coef_in[g]) == '0)) |-> (prod_q[g] == '0));
    end
endmodule

// File: rtl/sfir_addtree.sv
// Two-level registered adder tree for the four products.
// Each level grows by one bit; no rounding.
module sfir_addtree #(
    parameter int PROD_W = 33,
    parameter int PAIRS  = sfir_pkg::NUM_PAIRS,
    localparam int HALVES = PAIRS / 2,
    localparam int HALF_W = PROD_W + 1,
    localparam int OUT_W  = PROD_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod_in [PAIRS],
    output logic signed [OUT_W-1:0]  sum_q
);
    logic signed [HALF_W-1:0] half_q [HALVES];

    for (genvar g = 0; g < HALVES; g++) begin : g_lvl1
        // first level: adjacent product pairs
        always_ff @(posedge clk) begin
            if (!rst_n) half_q[g] <= '0;
            else        half_q[g] <= HALF_W'(prod_in[2*g]) + HALF_W'(prod_in[2*g+1]);
        end
    end

    // second level: final sum into the output register
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= OUT_W'(half_q[0]) + OUT_W'(half_q[1]);
    end
endmodule

// File: rtl/sfir_delay.sv
// Plain register chain used to balance the side output against the datapath.
module sfir_delay #(
    parameter int W     = 16,
    parameter int DEPTH = sfir_pkg::POST_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first balance register
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_in;
            end
        end else begin : g_next
            // following balance registers
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign d_out = stage_q[DEPTH-1];
endmodule

// File: rtl/sfir_pipe.sv
// Top of the pipelined symmetric eight-tap FIR.
// Stages: input capture, tap line, pre-add, product, half sum, output.
// The side output is delayed to line up with the filtered result.
module sfir_pipe #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    localparam int PAIRS  = sfir_pkg::NUM_PAIRS,
    localparam int TAPS   = sfir_pkg::NUM_TAPS,
    localparam int PRE_W  = DATA_W + 1,
    localparam int PROD_W = PRE_W + COEF_W,
    localparam int OUT_W  = PROD_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic signed [COEF_W-1:0] coef0,
    input  logic signed [COEF_W-1:0] coef1,
    input  logic signed [COEF_W-1:0] coef2,
    input  logic signed [COEF_W-1:0] coef3,
    output logic signed [OUT_W-1:0]  y_out,
    output logic signed [DATA_W-1:0] smp_tail
);
    logic signed [COEF_W-1:0] coef_in  [PAIRS];
    logic signed [DATA_W-1:0] tap      [TAPS];
    logic signed [COEF_W-1:0] coef_s1  [PAIRS];
    logic signed [PRE_W-1:0]  pre_sum  [PAIRS];
    logic signed [COEF_W-1:0] coef_s2  [PAIRS];
    logic signed [PROD_W-1:0] prod     [PAIRS];
    logic [DATA_W-1:0]        tail_bal;
    logic [4:0]               age_q;
    logic [2:0]               zrun_q;

    assign coef_in[0] = coef0;
    assign coef_in[1] = coef1;
    assign coef_in[2] = coef2;
    assign coef_in[3] = coef3;

    sfir_tapline #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_tapline (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .coef_in(coef_in),
        .tap_q(tap), .coef_q(coef_s1)
    );

    sfir_preadd #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_preadd (
        .clk(clk), .rst_n(rst_n), .tap_in(tap), .coef_in(coef_s1),
        .sum_q(pre_sum), .coef_q(coef_s2)
    );

    sfir_mult #(.PRE_W(PRE_W), .COEF_W(COEF_W), .PAIRS(PAIRS)) u_mult (
        .clk(clk), .rst_n(rst_n), .sum_in(pre_sum), .coef_in(coef_s2),
        .prod_q(prod)
    );

    sfir_addtree #(.PROD_W(PROD_W), .PAIRS(PAIRS)) u_addtree (
        .clk(clk), .rst_n(rst_n), .prod_in(prod), .sum_q(y_out)
    );

    sfir_delay #(.W(DATA_W), .DEPTH(sfir_pkg::POST_STAGES)) u_tail_bal (
        .clk(clk), .rst_n(rst_n), .d_in(tap[TAPS-1]), .d_out(tail_bal)
    );

    assign smp_tail = $signed(tail_bal);

    // edges since reset, saturating, for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 5'h1f) age_q <= age_q + 5'd1;
    end

    // consecutive edges with all weights zero, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun_q <= '0;
        else if ((coef0 | coef1 | coef2 | coef3) != '0)
            zrun_q <= '0;
        else if (zrun_q != 3'd7)
            zrun_q <= zrun_q + 3'd1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 5'd0) |-> (y_out == '0 && smp_tail == '0));

    // R2
    side_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 5'd13) |-> (smp_tail == $past(smp_in, 13)));

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zrun_q >= 3'd5) |-> (y_out == '0));
endmodule

// File: tb/test_sfir_pipe.sv
module test_sfir_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int COEF_W = 16;
    localparam int OUT_W  = DATA_W + COEF_W + 3;
    localparam int MAXN   = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [DATA_W-1:0] smp_in = '0;
    logic signed [COEF_W-1:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
    logic signed [OUT_W-1:0]  y_out;
    logic signed [DATA_W-1:0] smp_tail;

    int xs [MAXN];
    int hs [MAXN][4];
    int n = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string req_y = "R3";
    string req_x = "R2";

    sfir_pipe #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_sfir_pipe (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in),
        .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
        .y_out(y_out), .smp_tail(smp_tail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint xv(int k);
        if (k < 0) return 0;
        return longint'(xs[k]);
    endfunction

    function automatic longint y_exp(int k);
        if (k < 0) return 0;
        return longint'(hs[k][0]) * (xv(k-1) + xv(k-8))
             + longint'(hs[k][1]) * (xv(k-2) + xv(k-7))
             + longint'(hs[k][2]) * (xv(k-3) + xv(k-6))
             + longint'(hs[k][3]) * (xv(k-4) + xv(k-5));
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s step %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    // drive one sample and weights, pass one edge, check both outputs
    task automatic step(int x, int c0, int c1, int c2, int c3);
        smp_in = DATA_W'(x);
        coef0 = COEF_W'(c0); coef1 = COEF_W'(c1);
        coef2 = COEF_W'(c2); coef3 = COEF_W'(c3);
        xs[n] = x;
        hs[n][0] = c0; hs[n][1] = c1; hs[n][2] = c2; hs[n][3] = c3;
        @(posedge clk);
        @(negedge clk);
        check(req_y, longint'(y_out), y_exp(n - 4));
        check(req_x, longint'(smp_tail), xv(n - 12));
        n++;
    endtask

    function automatic int rnd_s(int w);
        int v;
        v = int'($urandom() & ((1 << w) - 1));
        if (v >= (1 << (w - 1))) v = v - (1 << w);
        return v;
    endfunction

    // reset with busy inputs, then confirm cleared outputs (R1)
    task automatic do_reset();
        rst_n = 1'b0;
        smp_in = 16'sh1234; coef0 = 16'sh0777; coef1 = -16'sd5;
        coef2 = 16'sd9; coef3 = 16'sd1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1", longint'(y_out), 0);
        check("R1", longint'(smp_tail), 0);
        rst_n = 1'b1;
        n = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R6 impulse response
        req_y = "R6"; req_x = "R2";
        step(1, 3, 5, 7, 11);
        for (int i = 0; i < 16; i++) step(0, 3, 5, 7, 11);

        // R4 weight changes on constant data, incl. single-cycle pulses
        req_y = "R4";
        for (int i = 0; i < 12; i++) step(100, 1, 1, 1, 1);
        for (int i = 0; i < 6; i++) step(100, 2, 2, 2, 2);
        step(100, -3, 4, -5, 6);
        for (int i = 0; i < 6; i++) step(100, 2, 2, 2, 2);
        step(100, 0, 0, 0, 9);
        for (int i = 0; i < 8; i++) step(100, 1, 1, 1, 1);

        // R7 zero weights with random data
        req_y = "R7";
        for (int i = 0; i < 24; i++) step(rnd_s(DATA_W), 0, 0, 0, 0);

        // R5 extreme values
        req_y = "R5";
        for (int i = 0; i < 16; i++) step(-32768, -32768, -32768, -32768, -32768);
        for (int i = 0; i < 16; i++) step(32767, -32768, -32768, -32768, -32768);
        for (int i = 0; i < 16; i++) step(32767, 32767, 32767, 32767, 32767);
        for (int i = 0; i < 12; i++) step(-32768, 32767, -32768, 32767, -32768);

        // R3 random stream
        req_y = "R3";
        for (int i = 0; i < 1200; i++)
            step(rnd_s(DATA_W), rnd_s(COEF_W), rnd_s(COEF_W), rnd_s(COEF_W), rnd_s(COEF_W));

        // R1 reset in the middle of traffic, then more random data
        do_reset();
        req_y = "R1";
        for (int i = 0; i < 5; i++) step(rnd_s(DATA_W), 7, -7, 3, 2);
        req_y = "R3";
        for (int i = 0; i < 300; i++)
            step(rnd_s(DATA_W), rnd_s(COEF_W), rnd_s(COEF_W), rnd_s(COEF_W), rnd_s(COEF_W));

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule